// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block sits on the host side of a byte-wide parallel flash device. It takes one request at a time to program a byte, erase a 128-byte sector or erase the whole device. It turns that request into the unlock-and-command write sequence that the device expects, then watches the device's status by reading the same location again and again until the internal operation has ended.

The flash is reached through a simple synchronous bus: a one-cycle write strobe with address and data, and a one-cycle read strobe whose data comes back on the next cycle. Completion is judged from bit 6 of the returned byte, which toggles on every read while the device is busy. A match between two reads is treated as a finish only after two more reads agree. After a program, the last value read is compared with the requested byte. A configurable limit on polling ends a hung operation with an error pulse.

Top module: `nvm_cmd_seq`

## Requirements
- R1: A program request (reqOp = 2'b00) issues exactly four writes in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then the request data at the request address.
- R2: A sector-erase request (reqOp = 2'b01) issues exactly six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 20h at the request address with its low 7 bits cleared.
- R3: A chip-erase request (reqOp = 2'b10 or 2'b11) issues the same first five writes as R2, then 10h@555h.
- R4: After the command writes, the block only reads until the operation ends. Each read is a one-cycle busRd pulse, and no cycle has both busWr and busRd. Polling reads use the request address for program and chip erase, and the sector base address for sector erase.
- R5: Bit 6 is compared between two consecutive reads. A difference means the device is still busy. A match is accepted only if the next two reads also agree on bit 6. Otherwise polling restarts with a fresh pair.
- R6: reqReady is high when idle. A request is taken when reqValid and reqReady are both high. reqReady then stays low until opDone or opError pulses. reqValid while reqReady is low has no effect.
- R7: After POLL_LIMIT comparisons that find bit 6 differing, the block pulses opError, does not pulse opDone, and returns to idle.
- R8: On an accepted finish of a program, the last byte read is compared with the requested data. A mismatch gives opError instead of opDone.
- R9: opDone and opError are one-cycle pulses and never occur together. After reset, reqReady is 1 and busWr, busRd, opDone and opError are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| reqAddr | input | ADDR_W | Target byte address |
| reqData | input | 8 | Byte to program |
| reqReady | output | 1 | Ready to accept a request |
| opDone | output | 1 | Operation finished correctly (pulse) |
| opError | output | 1 | Timeout or program mismatch (pulse) |
| busWr | output | 1 | Flash write strobe |
| busRd | output | 1 | Flash read strobe |
| busAddr | output | ADDR_W | Flash address |
| busWdata | output | 8 | Flash write data |
| busRdata | input | 8 | Flash read data, valid the cycle after busRd |

## Verification
The hardest case to reach is a false finish. In that case two status reads agree while the device is still busy, and only the confirming reads reveal it. A real device produces this only when its completion happens to line up with a read. The flash model in the bench has a knob that suppresses the toggle on one chosen read of an operation, which gives a matching pair in the middle of a long busy period. The bench then checks that opDone comes only after the model's busy time has run out. A second knob keeps the model busy forever, to drive the poll limit.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       wrEn;
    logic       rdEn;
    logic       capture;
    logic [2:0] step;
  } strobe_t;

  localparam logic [14:0] UNLOCK_ADDR_A = 15'h555;
  localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AA;
  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h20;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
endpackage

// File: rtl/nvm_seq_dp.sv
module nvm_seq_dp
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SECTOR_BITS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [7:0]        busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  output logic              lastStep,
  output logic              isProg,
  output logic              dq6Same,
  output logic              byteOk
);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLOCK_ADDR_B);

  op_e               opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic              prevDq6;
  logic [ADDR_W-1:0] sectorBase;
  logic [ADDR_W-1:0] pollAddr;
  logic [ADDR_W-1:0] cmdAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= OP_PROG;
      addrQ   <= '0;
      dataQ   <= '0;
      prevDq6 <= 1'b0;
    end else begin
      if (stb.load) begin
        opQ   <= reqOp[1] ? OP_CHIP : op_e'(reqOp);
        addrQ <= reqAddr;
        dataQ <= reqData;
      end
      if (stb.capture) prevDq6 <= busRdata[6];
    end
  end

  assign isProg     = (opQ == OP_PROG);
  assign sectorBase = {addrQ[ADDR_W-1:SECTOR_BITS], {SECTOR_BITS{1'b0}}};
  assign pollAddr   = (opQ == OP_SECT) ? sectorBase : addrQ;
  assign lastStep   = isProg ? (stb.step == 3'd3) : (stb.step == 3'd5);
  assign dq6Same    = (busRdata[6] == prevDq6);
  assign byteOk     = (busRdata == dataQ);

  always_comb begin
    cmdAddr  = ADDR_A;
    busWdata = KEY_A;
    case (stb.step)
      3'd1, 3'd4: begin
        cmdAddr  = ADDR_B;
        busWdata = KEY_B;
      end
      3'd2: busWdata = isProg ? CMD_PROG : CMD_ERASE;
      3'd3: if (isProg) begin
        cmdAddr  = addrQ;
        busWdata = dataQ;
      end
      3'd5: if (opQ == OP_SECT) begin
        cmdAddr  = sectorBase;
        busWdata = CMD_SECT;
      end else begin
        busWdata = CMD_CHIP;
      end
      default: ;
    endcase
  end

  assign busAddr = stb.rdEn ? pollAddr : cmdAddr;

  AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && lastStep && opQ == OP_SECT) |-> (busAddr[SECTOR_BITS-1:0] == '0 && busWdata == CMD_SECT)); // R2
  AST_FIRST_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && $past(stb.load)) |-> (busAddr == ADDR_A && busWdata == KEY_A)); // R1
  AST_POLL_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && opQ != OP_SECT) |-> (busAddr == addrQ)); // R4
endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 4096
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    lastStep,
  input  logic    isProg,
  input  logic    dq6Same,
  input  logic    byteOk,
  output logic    reqReady,
  output logic    opDone,
  output logic    opError,
  output logic    busWr,
  output logic    busRd,
  output strobe_t stb
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_RD, ST_CAP} state_e;

  state_e           state;
  logic [2:0]       stepQ;
  logic [1:0]       rdIdx;
  logic [CNT_W-1:0] pollCnt;
  logic             lastPoll;

  assign stb.load    = (state == ST_IDLE) && reqValid;
  assign stb.wrEn    = (state == ST_CMD);
  assign stb.rdEn    = (state == ST_RD);
  assign stb.capture = (state == ST_CAP);
  assign stb.step    = stepQ;
  assign busWr       = stb.wrEn;
  assign busRd       = stb.rdEn;
  assign reqReady    = (state == ST_IDLE);
  assign lastPoll    = (pollCnt == CNT_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepQ   <= '0;
      rdIdx   <= '0;
      pollCnt <= '0;
      opDone  <= 1'b0;
      opError <= 1'b0;
    end else begin
      opDone  <= 1'b0;
      opError <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_CMD;
          stepQ   <= '0;
          pollCnt <= '0;
        end
        ST_CMD: if (lastStep) begin
          state <= ST_RD;
          rdIdx <= '0;
        end else begin
          stepQ <= stepQ + 3'd1;
        end
        ST_RD: state <= ST_CAP;
        ST_CAP: begin
          state <= ST_RD;
          if (rdIdx == 2'd0 || rdIdx == 2'd2) begin
            rdIdx <= rdIdx + 2'd1;
          end else if (dq6Same) begin
            if (rdIdx == 2'd1) begin
              rdIdx <= 2'd2;
            end else begin
              state <= ST_IDLE;
              if (isProg && !byteOk) opError <= 1'b1;
              else                   opDone  <= 1'b1;
            end
          end else if (lastPoll) begin
            state   <= ST_IDLE;
            opError <= 1'b1;
          end else begin
            pollCnt <= pollCnt + 1'b1;
            rdIdx   <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(opDone && opError)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd)); // R4
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < CNT_W'(POLL_LIMIT)); // R7
  AST_END_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (opDone || opError) |-> ($past(state) == ST_CAP)); // R5
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SECTOR_BITS = 7,
  parameter int POLL_LIMIT  = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              reqReady,
  output logic              opDone,
  output logic              opError,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata
);
  strobe_t stb;
  logic    lastStep;
  logic    isProg;
  logic    dq6Same;
  logic    byteOk;

  nvm_seq_ctrl #(.POLL_LIMIT(POLL_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lastStep(lastStep),
    .isProg(isProg), .dq6Same(dq6Same), .byteOk(byteOk),
    .reqReady(reqReady), .opDone(opDone), .opError(opError),
    .busWr(busWr), .busRd(busRd), .stb(stb)
  );

  nvm_seq_dp #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .lastStep(lastStep), .isProg(isProg),
    .dq6Same(dq6Same), .byteOk(byteOk)
  );
endmodule

// File: tb/test_nvm_cmd_seq.sv
module test_nvm_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 11;
  localparam int MEM_SIZE   = 1 << AW;
  localparam int PLIM       = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'b00;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic          reqReady, opDone, opError, busWr, busRd;
  logic [AW-1:0] busAddr;
  logic [7:0]    busWdata;
  logic [7:0]    rdQ = 8'h00;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_cmd_seq #(.ADDR_W(AW), .SECTOR_BITS(7), .POLL_LIMIT(PLIM)) i_nvm_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .opDone(opDone), .opError(opError), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdQ)
  );

  // behavioural flash model
  logic [7:0]    mem [0:MEM_SIZE-1];
  int            stage = 0;
  int            busyCnt = 0;
  int            busyLen = 20;
  bit            stuck = 0;
  bit            kindProg = 0;
  logic [7:0]    progByte = 8'h00;
  logic          tog = 1'b0;
  int            rdInOp = 0;
  int            fakeIdx = -1;
  int            wrCnt = 0;
  logic [AW-1:0] wrA [0:15];
  logic [7:0]    wrD [0:15];
  int            badRdAddr = 0;
  logic [AW-1:0] expRdAddr = '0;

  task automatic startBusy(input bit prog);
    kindProg = prog;
    busyCnt  = busyLen;
    tog      = 1'b0;
    rdInOp   = 0;
  endtask

  always @(posedge clk) begin
    if (busyCnt > 0 && !stuck) busyCnt = busyCnt - 1;
    if (busWr) begin
      if (wrCnt < 16) begin
        wrA[wrCnt] = busAddr;
        wrD[wrCnt] = busWdata;
      end
      wrCnt = wrCnt + 1;
      if (busyCnt == 0) begin
        case (stage)
          0: stage = (busAddr == 11'h555 && busWdata == 8'hAA) ? 1 : 0;
          1: stage = (busAddr == 11'h2AA && busWdata == 8'h55) ? 2 : 0;
          2: if (busAddr == 11'h555 && busWdata == 8'hA0) stage = 10;
             else if (busAddr == 11'h555 && busWdata == 8'h80) stage = 3;
             else stage = 0;
          3: stage = (busAddr == 11'h555 && busWdata == 8'hAA) ? 4 : 0;
          4: stage = (busAddr == 11'h2AA && busWdata == 8'h55) ? 5 : 0;
          5: begin
            if (busWdata == 8'h20) begin
              for (int i = 0; i < 128; i++) mem[{busAddr[AW-1:7], 7'd0} + AW'(i)] = 8'hFF;
              startBusy(1'b0);
            end else if (busWdata == 8'h10 && busAddr == 11'h555) begin
              for (int i = 0; i < MEM_SIZE; i++) mem[i] = 8'hFF;
              startBusy(1'b0);
            end
            stage = 0;
          end
          10: begin
            mem[busAddr] = mem[busAddr] & busWdata;
            progByte = busWdata;
            startBusy(1'b1);
            stage = 0;
          end
          default: stage = 0;
        endcase
      end
    end
    if (busRd) begin
      if (busAddr != expRdAddr) badRdAddr = badRdAddr + 1;
      if (busyCnt > 0) begin
        if (rdInOp != fakeIdx) tog = ~tog;
        rdQ <= {kindProg ? ~progByte[7] : 1'b0, tog, 6'b0};
      end else begin
        rdQ <= mem[busAddr];
      end
      rdInOp = rdInOp + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       output bit gotDone, output bit gotErr, output int cycles);
    wrCnt     = 0;
    badRdAddr = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R6 ready low after accept", int'(reqReady), 0);
    cycles = 1; gotDone = 0; gotErr = 0;
    while (!opDone && !opError && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    gotDone = opDone;
    gotErr  = opError;
    @(negedge clk);
    chk(reqReady == 1'b1, "R6 ready after end", int'(reqReady), 1);
  endtask

  task automatic t_reset();
    chk(reqReady == 1'b1, "R9 reset ready", int'(reqReady), 1);
    chk(!busWr && !busRd, "R9 reset strobes", int'({busWr, busRd}), 0);
    chk(!opDone && !opError, "R9 reset pulses", int'({opDone, opError}), 0);
  endtask

  task automatic t_program();
    bit dn, er; int cy;
    busyLen = 30; expRdAddr = 11'h123;
    runOp(2'b00, 11'h123, 8'h5A, dn, er, cy);
    chk(dn && !er, "R5 program done", int'({dn, er}), 2);
    chk(wrCnt == 4, "R4 program write count", wrCnt, 4);
    chk(wrA[0] == 11'h555 && wrD[0] == 8'hAA, "R1 write 0", int'(wrD[0]), 'hAA);
    chk(wrA[1] == 11'h2AA && wrD[1] == 8'h55, "R1 write 1", int'(wrD[1]), 'h55);
    chk(wrA[2] == 11'h555 && wrD[2] == 8'hA0, "R1 write 2", int'(wrD[2]), 'hA0);
    chk(wrA[3] == 11'h123 && wrD[3] == 8'h5A, "R1 write 3", int'(wrA[3]), 'h123);
    chk(mem[11'h123] == 8'h5A, "R1 byte stored", int'(mem[11'h123]), 'h5A);
    chk(badRdAddr == 0, "R4 poll address", badRdAddr, 0);
    chk(busyCnt == 0, "R5 done after busy", busyCnt, 0);
  endtask

  task automatic t_sector();
    bit dn, er; int cy;
    mem[11'h2C5] = 8'h00; mem[11'h27F] = 8'h33;
    busyLen = 40; expRdAddr = 11'h280;
    runOp(2'b01, 11'h2C5, 8'h00, dn, er, cy);
    chk(dn && !er, "R2 sector done", int'({dn, er}), 2);
    chk(wrCnt == 6, "R2 sector write count", wrCnt, 6);
    chk(wrD[2] == 8'h80 && wrD[3] == 8'hAA && wrA[4] == 11'h2AA, "R2 middle writes", int'(wrD[2]), 'h80);
    chk(wrA[5] == 11'h280 && wrD[5] == 8'h20, "R2 sector base", int'(wrA[5]), 'h280);
    chk(mem[11'h2C5] == 8'hFF, "R2 sector erased", int'(mem[11'h2C5]), 'hFF);
    chk(mem[11'h27F] == 8'h33, "R2 neighbour kept", int'(mem[11'h27F]), 'h33);
    chk(badRdAddr == 0, "R4 sector poll address", badRdAddr, 0);
  endtask

  task automatic t_chip();
    bit dn, er; int cy;
    busyLen = 50; expRdAddr = 11'h7F1;
    runOp(2'b11, 11'h7F1, 8'h00, dn, er, cy);
    chk(dn && !er, "R3 chip done", int'({dn, er}), 2);
    chk(wrCnt == 6 && wrA[5] == 11'h555 && wrD[5] == 8'h10, "R3 last write", int'(wrD[5]), 'h10);
    chk(mem[11'h27F] == 8'hFF && mem[11'h123] == 8'hFF, "R3 all erased", int'(mem[11'h123]), 'hFF);
  endtask

  task automatic t_race();
    bit dn, er; int cy;
    busyLen = 60; fakeIdx = 1; expRdAddr = 11'h010;
    runOp(2'b00, 11'h010, 8'h3C, dn, er, cy);
    fakeIdx = -1;
    chk(dn && !er, "R5 race done", int'({dn, er}), 2);
    chk(busyCnt == 0, "R5 no early finish", busyCnt, 0);
    chk(cy >= 60, "R5 race duration", cy, 60);
  endtask

  task automatic t_ignore();
    bit dn, er;
    int cy;
    busyLen = 30; expRdAddr = 11'h200; wrCnt = 0; badRdAddr = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'b00; reqAddr = 11'h200; reqData = 8'h77;
    @(negedge clk);
    reqOp = 2'b10; reqAddr = 11'h555; reqData = 8'h00;
    repeat (8) @(negedge clk);
    reqValid = 1'b0;
    cy = 0;
    while (!opDone && !opError && cy < 20000) begin
      @(negedge clk);
      cy++;
    end
    dn = opDone; er = opError;
    chk(dn && !er, "R6 first request done", int'({dn, er}), 2);
    chk(wrCnt == 4, "R6 extra request ignored", wrCnt, 4);
    chk(mem[11'h201] == 8'hFF && mem[11'h200] == 8'h77, "R6 memory only programmed", int'(mem[11'h200]), 'h77);
    @(negedge clk);
  endtask

  task automatic t_stuck();
    bit dn, er; int cy;
    busyLen = 5; stuck = 1; expRdAddr = 11'h400;
    runOp(2'b01, 11'h400, 8'h00, dn, er, cy);
    chk(er && !dn, "R7 timeout error", int'({dn, er}), 1);
    chk(cy >= 4 * PLIM, "R7 poll limit reached", cy, 4 * PLIM);
    stuck = 0; busyCnt = 0;
  endtask

  task automatic t_mismatch();
    bit dn, er; int cy;
    mem[11'h055] = 8'h0F; busyLen = 20; expRdAddr = 11'h055;
    runOp(2'b00, 11'h055, 8'hF0, dn, er, cy);
    chk(er && !dn, "R8 program mismatch", int'({dn, er}), 1);
    chk(mem[11'h055] == 8'h00, "R8 model content", int'(mem[11'h055]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_SIZE; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_sector();
    t_chip();
    t_race();
    t_ignore();
    t_stuck();
    t_mismatch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule